// File: doc/BRIEF.md
# Cross-Referenced Clock Monitor Reference Divider

This block lets two free-running clock sources watch each other. A low-frequency base clock from the on-chip oscillator and an external clock are each divided down into a slow reference. The base-clock reference is then sampled in the external-clock domain, and the external-clock reference is sampled in the base-clock domain. A source is considered alive while edges from its reference keep arriving at the other side.

Each source always passes through a fixed divide-by-four stage. A longer divide-by-`LONG_DIV` stage (64 by default) is added on one side only, so that each reference stays well below the clock that samples it. The configuration input `ext_slow` chooses that side. When `ext_slow` is high, the external source is the slower one, so the base clock gets the long stage. When `ext_slow` is low, the external clock gets it.

Monitoring is switched on through a sticky flag. It can be set only while both sources report stable. After that it stays set until an explicit disable or a reset.

Top module: `xref_clk_monitor`

## Requirements
- R1: While `rst_n` is low, `int_ref`, `ext_ref`, `mon_active`, `ext_alive` and `int_alive` are all low.
- R2: With `ext_slow` low, `int_ref` has a period of 4 base-clock cycles and is high for 2 of them.
- R3: With `ext_slow` high, `int_ref` has a period of 4*`LONG_DIV` base-clock cycles (256 by default) and is high for half of them.
- R4: With `ext_slow` low, `ext_ref` has a period of 4*`LONG_DIV` external-clock cycles and is high for half of them.
- R5: With `ext_slow` high, `ext_ref` has a period of 4 external-clock cycles and is high for 2 of them.
- R6: A `mon_en_req` seen at a base-clock edge while `int_stable` and `ext_stable` are both high, and `mon_dis_req` is low, makes `mon_active` high after that edge.
- R7: A `mon_en_req` seen while either stable flag is low has no effect, so `mon_active` stays low.
- R8: Once `mon_active` is set, it stays set when either stable flag later goes low, as long as `mon_dis_req` stays low.
- R9: `mon_dis_req` high at a base-clock edge clears `mon_active`. It takes priority over an enable request at the same edge.
- R10: `ext_alive` is updated in the base-clock domain. It is high while edges of `ext_ref` keep arriving through a `SYNC_STAGES`-flop synchronizer. It falls once no edge has arrived for `WINDOW` base-clock cycles (512 by default).
- R11: `int_alive` is updated in the external-clock domain. It is high while edges of `int_ref` keep arriving through the synchronizer. It falls once no edge has arrived for `WINDOW` external-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ibase_clk | input | 1 | Low-frequency internal base clock |
| ext_clk | input | 1 | External clock source |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| int_stable | input | 1 | The internal source reports stable |
| ext_stable | input | 1 | The external source reports stable |
| ext_slow | input | 1 | High: the long stage goes on the base clock. Low: it goes on the external clock |
| mon_en_req | input | 1 | Request to switch monitoring on (base-clock domain) |
| mon_dis_req | input | 1 | Request to switch monitoring off (base-clock domain) |
| int_ref | output | 1 | Divided reference derived from the base clock |
| ext_ref | output | 1 | Divided reference derived from the external clock |
| mon_active | output | 1 | Sticky flag showing that monitoring is on |
| ext_alive | output | 1 | Edges of the external reference are being seen (base-clock domain) |
| int_alive | output | 1 | Edges of the base reference are being seen (external-clock domain) |

## Verification
`mon_active` is registered on the base clock, so its value is due one base-clock edge after the request. The bench drives each request on a falling edge and checks one nanosecond after the next rising edge.

The reference periods do not depend on when reset is released. The bench therefore measures the time between rising and falling edges of each reference and compares it with the selected ratio times the source period.

The activity flags pass through two synchronizer flops plus a `WINDOW`-cycle counter. The bench stops one clock, waits a short span that is still inside the window and checks that the flag holds. It then waits well past the window plus the synchronizer delay before checking that the flag has fallen, and after a restart it checks that the flag rises again.

// File: rtl/xref_pkg.sv
`timescale 1ns/1ps
package xref_pkg;
   typedef enum logic {TAP_SHORT = 1'b0, TAP_LONG = 1'b1} tap_e;

   // Pick the divider tap for one side from the slow-source setting.
   function automatic tap_e side_tap(input logic ext_is_slow, input logic internal_side);
      if (internal_side) return ext_is_slow ? TAP_LONG : TAP_SHORT;
      else               return ext_is_slow ? TAP_SHORT : TAP_LONG;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/xref_ref_divider.sv
`timescale 1ns/1ps
module xref_ref_divider
   import xref_pkg::*;
#(
   parameter int LONG_DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  tap_e tap,
   output logic ref_out
);
   localparam int BASE_DIV  = 4;
   localparam int TOTAL_DIV = BASE_DIV * LONG_DIV;
   localparam int CW        = $clog2(TOTAL_DIV);
   localparam int SHORT_BIT = $clog2(BASE_DIV) - 1;
   localparam int LONG_BIT  = CW - 1;

   if (!is_pow2(LONG_DIV) || LONG_DIV < 2) begin : g_bad_long
      $error("xref_ref_divider: LONG_DIV must be a power of two of at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;

   assign cnt_nx = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ref_out <= 1'b0;
      end else begin
         cnt_q   <= cnt_nx;
         ref_out <= (tap == TAP_LONG) ? cnt_nx[LONG_BIT] : cnt_nx[SHORT_BIT];
      end
   end
endmodule

// File: rtl/xref_activity_watch.sv
`timescale 1ns/1ps
module xref_activity_watch #(
   parameter int SYNC_STAGES = 2,
   parameter int WINDOW      = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   output logic alive
);
   localparam int CNTW = $clog2(WINDOW + 1);
   localparam logic [CNTW-1:0] LAST = CNTW'(WINDOW - 1);
   localparam logic [CNTW-1:0] FULL = CNTW'(WINDOW);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xref_activity_watch: SYNC_STAGES must be at least 2");
   end
   if (WINDOW < 4) begin : g_bad_window
      $error("xref_activity_watch: WINDOW must be at least 4");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   edge_seen;
   logic [CNTW-1:0]        idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ref_in};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign edge_seen = sync_q[SYNC_STAGES-1] ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= '0;
         alive  <= 1'b0;
      end else if (edge_seen) begin
         idle_q <= '0;
         alive  <= 1'b1;
      end else begin
         if (idle_q != FULL) idle_q <= idle_q + 1'b1;
         if (idle_q == LAST) alive <= 1'b0;
      end
   end
endmodule

// File: rtl/xref_enable_latch.sv
`timescale 1ns/1ps
module xref_enable_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic both_stable,
   input  logic en_req,
   input  logic dis_req,
   output logic active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      active <= 1'b0;
      else if (dis_req)                active <= 1'b0;
      else if (en_req && both_stable)  active <= 1'b1;
   end
endmodule

// File: rtl/xref_clk_monitor.sv
`timescale 1ns/1ps
module xref_clk_monitor
   import xref_pkg::*;
#(
   parameter int LONG_DIV    = 64,
   parameter int SYNC_STAGES = 2,
   parameter int WINDOW      = 512
) (
   input  logic ibase_clk,
   input  logic ext_clk,
   input  logic rst_n,
   input  logic int_stable,
   input  logic ext_stable,
   input  logic ext_slow,
   input  logic mon_en_req,
   input  logic mon_dis_req,
   output logic int_ref,
   output logic ext_ref,
   output logic mon_active,
   output logic ext_alive,
   output logic int_alive
);
   if (!is_pow2(LONG_DIV) || LONG_DIV < 2) begin : g_bad_long
      $error("xref_clk_monitor: LONG_DIV must be a power of two of at least 2");
   end

   tap_e int_tap;
   tap_e ext_tap;

   assign int_tap = side_tap(ext_slow, 1'b1);
   assign ext_tap = side_tap(ext_slow, 1'b0);

   xref_ref_divider #(.LONG_DIV(LONG_DIV)) u_int_div (
      .clk(ibase_clk), .rst_n(rst_n), .tap(int_tap), .ref_out(int_ref)
   );

   xref_ref_divider #(.LONG_DIV(LONG_DIV)) u_ext_div (
      .clk(ext_clk), .rst_n(rst_n), .tap(ext_tap), .ref_out(ext_ref)
   );

   // The external reference is watched from the base domain and vice versa.
   xref_activity_watch #(.SYNC_STAGES(SYNC_STAGES), .WINDOW(WINDOW)) u_watch_ext (
      .clk(ibase_clk), .rst_n(rst_n), .ref_in(ext_ref), .alive(ext_alive)
   );

   xref_activity_watch #(.SYNC_STAGES(SYNC_STAGES), .WINDOW(WINDOW)) u_watch_int (
      .clk(ext_clk), .rst_n(rst_n), .ref_in(int_ref), .alive(int_alive)
   );

   xref_enable_latch u_enable (
      .clk(ibase_clk), .rst_n(rst_n),
      .both_stable(int_stable && ext_stable),
      .en_req(mon_en_req), .dis_req(mon_dis_req),
      .active(mon_active)
   );
endmodule

module xref_clk_monitor_chk (
   input logic ibase_clk,
   input logic rst_n,
   input logic int_stable,
   input logic ext_stable,
   input logic mon_en_req,
   input logic mon_dis_req,
   input logic int_ref,
   input logic mon_active,
   input logic ext_alive
);
   // R1: base-domain outputs are quiet while reset is held
   a_r1_reset_quiet: assert property (@(posedge ibase_clk)
      !rst_n |-> (!mon_active && !int_ref && !ext_alive));

   // R6: a qualified enable request sets the flag at the next edge
   a_r6_enable_sets: assert property (@(posedge ibase_clk) disable iff (!rst_n)
      (mon_en_req && int_stable && ext_stable && !mon_dis_req) |=> mon_active);

   // R7: without a qualified request the flag cannot rise
   a_r7_no_unqualified_set: assert property (@(posedge ibase_clk) disable iff (!rst_n)
      (!mon_active && !(mon_en_req && int_stable && ext_stable)) |=> !mon_active);

   // R8: the flag is sticky unless disabled
   a_r8_sticky: assert property (@(posedge ibase_clk) disable iff (!rst_n)
      (mon_active && !mon_dis_req) |=> mon_active);

   // R9: disable clears the flag
   a_r9_disable_clears: assert property (@(posedge ibase_clk) disable iff (!rst_n)
      mon_dis_req |=> !mon_active);
endmodule

bind xref_clk_monitor xref_clk_monitor_chk u_chk (
   .ibase_clk(ibase_clk), .rst_n(rst_n), .int_stable(int_stable),
   .ext_stable(ext_stable), .mon_en_req(mon_en_req), .mon_dis_req(mon_dis_req),
   .int_ref(int_ref), .mon_active(mon_active), .ext_alive(ext_alive)
);

// File: tb/tb_xref_clk_monitor.sv
`timescale 1ns/1ps
module tb_xref_clk_monitor;
   localparam int LONG_DIV = 64;
   localparam int WINDOW   = 512;
   localparam int CLK_NS   = 8;

   logic clk = 1'b0;
   logic ibase_run = 1'b1;
   logic eclk = 1'b0;
   logic eclk_run = 1'b1;
   int   ehalf = 10;
   logic ibase_clk;

   logic rst_n = 1'b0;
   logic int_stable = 1'b0, ext_stable = 1'b0, ext_slow = 1'b1;
   logic mon_en_req = 1'b0, mon_dis_req = 1'b0;
   logic int_ref, ext_ref, mon_active, ext_alive, int_alive;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #(CLK_NS/2) clk = ~clk;
   assign ibase_clk = clk & ibase_run;

   always begin
      if (eclk_run) #(ehalf) eclk = ~eclk;
      else #1;
   end

   xref_clk_monitor #(.LONG_DIV(LONG_DIV), .SYNC_STAGES(2), .WINDOW(WINDOW)) dut (
      .ibase_clk(ibase_clk), .ext_clk(eclk), .rst_n(rst_n),
      .int_stable(int_stable), .ext_stable(ext_stable), .ext_slow(ext_slow),
      .mon_en_req(mon_en_req), .mon_dis_req(mon_dis_req),
      .int_ref(int_ref), .ext_ref(ext_ref), .mon_active(mon_active),
      .ext_alive(ext_alive), .int_alive(int_alive)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic do_reset(input logic slow, input int half_ns);
      @(negedge clk);
      rst_n = 1'b0;
      ext_slow = slow;
      ehalf = half_ns;
      mon_en_req = 1'b0;
      mon_dis_req = 1'b0;
      repeat (5) @(negedge clk);
      check("R1 int_ref in reset", int'(int_ref), 0);
      check("R1 ext_ref in reset", int'(ext_ref), 0);
      check("R1 mon_active in reset", int'(mon_active), 0);
      check("R1 alive flags in reset", int'(ext_alive) + int'(int_alive), 0);
      rst_n = 1'b1;
   endtask

   task automatic measure(input bit ext_side, input string tag, input int exp_period, input int exp_high);
      realtime t0, t1, t2;
      if (ext_side) begin
         @(posedge ext_ref); t0 = $realtime;
         @(negedge ext_ref); t1 = $realtime;
         @(posedge ext_ref); t2 = $realtime;
      end else begin
         @(posedge int_ref); t0 = $realtime;
         @(negedge int_ref); t1 = $realtime;
         @(posedge int_ref); t2 = $realtime;
      end
      check({tag, " period ns"}, $rtoi(t2 - t0), exp_period);
      check({tag, " high ns"}, $rtoi(t1 - t0), exp_high);
   endtask

   task automatic test_dividers_slow_ext;
      do_reset(1'b1, 10);
      measure(1'b0, "R3 int_ref long", CLK_NS * 4 * LONG_DIV, CLK_NS * 2 * LONG_DIV);
      measure(1'b1, "R5 ext_ref short", 20 * 4, 20 * 2);
   endtask

   task automatic test_dividers_fast_ext;
      do_reset(1'b0, 2);
      measure(1'b0, "R2 int_ref short", CLK_NS * 4, CLK_NS * 2);
      measure(1'b1, "R4 ext_ref long", 4 * 4 * LONG_DIV, 4 * 2 * LONG_DIV);
   endtask

   task automatic step_req(input logic en, input logic dis, input logic is, input logic es);
      @(negedge clk);
      mon_en_req = en; mon_dis_req = dis; int_stable = is; ext_stable = es;
      @(posedge clk); #1;
      mon_en_req = 1'b0; mon_dis_req = 1'b0;
   endtask

   task automatic test_monitor_flag;
      do_reset(1'b1, 10);
      step_req(1'b1, 1'b0, 1'b1, 1'b0);
      check("R7 enable with ext unstable", int'(mon_active), 0);
      step_req(1'b1, 1'b0, 1'b0, 1'b1);
      check("R7 enable with int unstable", int'(mon_active), 0);
      step_req(1'b1, 1'b0, 1'b1, 1'b1);
      check("R6 enable with both stable", int'(mon_active), 1);
      step_req(1'b0, 1'b0, 1'b0, 1'b1);
      check("R8 stays set after int unstable", int'(mon_active), 1);
      step_req(1'b0, 1'b0, 1'b0, 1'b0);
      repeat (3) @(posedge clk); #1;
      check("R8 stays set with both unstable", int'(mon_active), 1);
      step_req(1'b0, 1'b1, 1'b1, 1'b1);
      check("R9 disable clears", int'(mon_active), 0);
      step_req(1'b1, 1'b0, 1'b1, 1'b1);
      check("R6 re-enable", int'(mon_active), 1);
      step_req(1'b1, 1'b1, 1'b1, 1'b1);
      check("R9 disable beats enable", int'(mon_active), 0);
   endtask

   task automatic test_activity;
      do_reset(1'b0, 2);
      repeat (300) @(negedge clk);
      check("R10 ext_alive while running", int'(ext_alive), 1);
      check("R11 int_alive while running", int'(int_alive), 1);
      eclk_run = 1'b0;
      repeat (30) @(negedge clk);
      check("R10 ext_alive inside window", int'(ext_alive), 1);
      repeat (650) @(negedge clk);
      check("R10 ext_alive after idle window", int'(ext_alive), 0);
      eclk_run = 1'b1;
      repeat (200) @(negedge clk);
      check("R10 ext_alive after restart", int'(ext_alive), 1);
      ibase_run = 1'b0;
      #20;
      check("R11 int_alive inside window", int'(int_alive), 1);
      repeat (400) @(negedge clk);
      check("R11 int_alive after idle window", int'(int_alive), 0);
      ibase_run = 1'b1;
      repeat (50) @(negedge clk);
      check("R11 int_alive after restart", int'(int_alive), 1);
   endtask

   initial begin
      test_dividers_slow_ext();
      test_dividers_fast_ext();
      test_monitor_flag();
      test_activity();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule